// File: doc/BRIEF.md
# Calendar Time Counter with Stop Control

This block keeps calendar time: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `tick_1hz` advances the time by one second. Carries ripple from seconds up to the year. Month lengths and leap Februaries are handled in hardware.

Software reaches every field through a simple register port. Writes are synchronous and reads are combinational. Each field has its own 32-bit register, and the registers sit in a contiguous bank. A stop bit in a separate control register freezes counting, so a new time can be loaded without a carry landing between two field writes. Software takes a consistent snapshot by reading seconds first, then the other fields, then seconds again. It keeps the snapshot when the two seconds values match.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the stop bit is 1. The fields read year 0, month 1, day of month 1, day of week 0, hour 0, minute 0 and second 0.
- R2: The control register at address 0x20 holds the stop bit in bit 0, and its other bits read 0. While the stop bit is 1, ticks have no effect on any field. Writing 0 to it lets the next tick advance the time.
- R3: With the stop bit 0, each tick adds one to the seconds field. Seconds at 59 or above return to 0 and add one to the minutes. Minutes at 59 or above return to 0 and add one to the hours. Hours at 23 or above return to 0 and start a new day.
- R4: On a new day, day of week counts 0 to 6 and then returns to 0. Day of month adds one, or returns to 1 and advances the month once it has reached the length of the month. Months 4, 6, 9 and 11 have 30 days. February follows R6. Every other month value has 31 days.
- R5: Month is one-based. From 12 or above it returns to 1 and the year adds one. The year counts 0 to 99, and incrementing from 99 wraps it to 0.
- R6: February has 29 days when the year is a non-zero multiple of 4. In every other year it has 28 days, and year 0 counts as a non-leap year.
- R7: Field addresses run in a fixed order at a 4-byte step from 0x40: year 0x40, month 0x44, day of month 0x48, day of week 0x4C, hour 0x50, minute 0x54, second 0x58.
- R8: A field write takes effect at the clock edge that samples it, whatever the stop bit holds. The write keeps the low bits of the field's width: second and minute 6 bits, hour 5, day of week 3, day of month 5, month 4, year 7.
- R9: If a field write and a counting tick fall in the same cycle, the written value wins for that field.
- R10: Whenever counting changes any field, the seconds field changes on the same edge. Software can therefore trust a snapshot when its two seconds reads agree.
- R11: Reading any address outside the control register and the seven field registers returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse that advances the time by one second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Combinational read data |

## Verification
A write, or a tick together with its whole carry chain, changes the registers at the clock edge that samples it. A read returns data in the same cycle as its address. Every result is therefore visible one edge after the stimulus. The bench drives inputs on the falling edge and advances its reference model on the rising edge. On the next falling edge it compares the register it has selected, rotating through the whole bank. Directed checks at month ends, leap Februaries, the year wrap and a write colliding with a tick sample in that same half-cycle, after the edge that applied the stimulus.

// File: rtl/cal_time_counter.sv
module cal_time_counter #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CTRL_OFS   = 'h20,
  parameter int FIELD_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(FIELD_BASE);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(FIELD_BASE + 4);
  localparam logic [ADDR_W-1:0] A_DOM  = ADDR_W'(FIELD_BASE + 8);
  localparam logic [ADDR_W-1:0] A_DOW  = ADDR_W'(FIELD_BASE + 12);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(FIELD_BASE + 16);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(FIELD_BASE + 20);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(FIELD_BASE + 24);

  logic       stop_q;
  logic [5:0] sec_q, min_q;
  logic [4:0] hour_q, dom_q;
  logic [2:0] dow_q;
  logic [3:0] mon_q;
  logic [6:0] year_q;

  logic       leap;
  logic [4:0] mlen;
  logic       adv, c_min, c_hour, c_day, c_mon, c_year;

  assign leap   = (year_q[1:0] == 2'd0) && (year_q != 7'd0);
  assign adv    = tick_1hz && !stop_q;
  assign c_min  = adv && (sec_q >= 6'd59);
  assign c_hour = c_min && (min_q >= 6'd59);
  assign c_day  = c_hour && (hour_q >= 5'd23);
  assign c_mon  = c_day && (dom_q >= mlen);
  assign c_year = c_mon && (mon_q >= 4'd12);

  always_comb begin
    case (mon_q)
      4'd2:                      mlen = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
      default:                   mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      dow_q  <= '0;
      dom_q  <= 5'd1;
      mon_q  <= 4'd1;
      year_q <= '0;
    end else begin
      if (adv)    sec_q  <= c_min  ? 6'd0 : sec_q + 6'd1;
      if (c_min)  min_q  <= c_hour ? 6'd0 : min_q + 6'd1;
      if (c_hour) hour_q <= c_day  ? 5'd0 : hour_q + 5'd1;
      if (c_day) begin
        dow_q <= (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
        dom_q <= c_mon ? 5'd1 : dom_q + 5'd1;
      end
      if (c_mon)  mon_q  <= c_year ? 4'd1 : mon_q + 4'd1;
      if (c_year) year_q <= (year_q >= 7'd99) ? 7'd0 : year_q + 7'd1;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: stop_q <= wr_data[0];
          A_YEAR: year_q <= wr_data[6:0];
          A_MON:  mon_q  <= wr_data[3:0];
          A_DOM:  dom_q  <= wr_data[4:0];
          A_DOW:  dow_q  <= wr_data[2:0];
          A_HOUR: hour_q <= wr_data[4:0];
          A_MIN:  min_q  <= wr_data[5:0];
          A_SEC:  sec_q  <= wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(stop_q);
      A_YEAR:  rd_data = DATA_W'(year_q);
      A_MON:   rd_data = DATA_W'(mon_q);
      A_DOM:   rd_data = DATA_W'(dom_q);
      A_DOW:   rd_data = DATA_W'(dow_q);
      A_HOUR:  rd_data = DATA_W'(hour_q);
      A_MIN:   rd_data = DATA_W'(min_q);
      A_SEC:   rd_data = DATA_W'(sec_q);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIELD_BASE = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              stop_q,
  input logic [5:0]        sec_q,
  input logic [5:0]        min_q,
  input logic [4:0]        hour_q,
  input logic [4:0]        dom_q,
  input logic [2:0]        dow_q,
  input logic [3:0]        mon_q,
  input logic [6:0]        year_q
);

  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(FIELD_BASE + 24);

  p_frozen_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                            $stable(dom_q) && $stable(mon_q) && $stable(year_q)));

  p_minute_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !stop_q && !wr_en && sec_q == 6'd59 && min_q < 6'd59)
      |=> (sec_q == 6'd0 && min_q == $past(min_q) + 6'd1));

  p_new_day_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !stop_q && !wr_en && sec_q == 6'd59 && min_q == 6'd59 && hour_q == 5'd23)
      |=> (hour_q == 5'd0 && !$stable(dow_q)));

  p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (year_q == 7'd99 && !wr_en) |=> (year_q == 7'd99 || year_q == 7'd0));

  p_write_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SEC) |=> (sec_q == $past(wr_data[5:0])));

  p_sec_moves_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(sec_q) ||
                ($stable(min_q) && $stable(hour_q) && $stable(dow_q) &&
                 $stable(dom_q) && $stable(mon_q) && $stable(year_q))));

endmodule

bind cal_time_counter cal_time_counter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .stop_q(stop_q),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dom_q(dom_q),
  .dow_q(dow_q), .mon_q(mon_q), .year_q(year_q)
);

// File: tb/cal_time_counter_tb_top.sv
`timescale 1ns/1ps
module cal_time_counter_tb_top;
  localparam int CTRL = 'h20, YR = 'h40, MO = 'h44, DM = 'h48, DW = 'h4C,
                 HR = 'h50, MN = 'h54, SC = 'h58;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = 8'h20;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit probe = 1'b0;
  int rot = 0;

  int m_stop, m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr;

  always #5 clk = ~clk;

  cal_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int month_days(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0 && yr != 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int model_val(int a);
    case (a)
      CTRL: return m_stop;
      YR: return m_yr;
      MO: return m_mon;
      DM: return m_dom;
      DW: return m_dow;
      HR: return m_hr;
      MN: return m_min;
      SC: return m_sec;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      CTRL: return "R2";
      YR, MO: return "R5";
      DM, DW: return "R4";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stop = 1; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_dom = 1; m_mon = 1; m_yr = 0;
    end else begin
      int s, mi, h, dw, dm, mo, y;
      s = m_sec; mi = m_min; h = m_hr; dw = m_dow; dm = m_dom; mo = m_mon; y = m_yr;
      if (tick_1hz && m_stop == 0) begin
        if (m_sec >= 59) begin
          s = 0;
          if (m_min >= 59) begin
            mi = 0;
            if (m_hr >= 23) begin
              h = 0;
              dw = (m_dow >= 6) ? 0 : m_dow + 1;
              if (m_dom >= month_days(m_mon, m_yr)) begin
                dm = 1;
                if (m_mon >= 12) begin
                  mo = 1;
                  y = (m_yr >= 99) ? 0 : m_yr + 1;
                end else mo = m_mon + 1;
              end else dm = m_dom + 1;
            end else h = m_hr + 1;
          end else mi = m_min + 1;
        end else s = m_sec + 1;
      end
      if (wr_en) begin
        case (int'(wr_addr))
          CTRL: m_stop = int'(wr_data & 32'h1);
          YR: y  = int'(wr_data & 32'h7F);
          MO: mo = int'(wr_data & 32'hF);
          DM: dm = int'(wr_data & 32'h1F);
          DW: dw = int'(wr_data & 32'h7);
          HR: h  = int'(wr_data & 32'h1F);
          MN: mi = int'(wr_data & 32'h3F);
          SC: s  = int'(wr_data & 32'h3F);
          default: ;
        endcase
      end
      m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_dom = dm; m_mon = mo; m_yr = y;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !probe) begin
      int a, e;
      a = int'(rd_addr);
      e = model_val(a);
      n_cmp++;
      if (rd_data !== 32'(e)) begin
        n_bad++;
        $display("FAIL %s addr 0x%0h: actual %0d expected %0d", tag_of(a), a, rd_data, e);
      end
      rot = (rot + 1) % 8;
      rd_addr = (rot == 0) ? 8'(CTRL) : 8'(YR + 4 * (rot - 1));
    end
  end

  task automatic chk(input int a, input int exp, input string tag);
    probe = 1'b1;
    @(negedge clk);
    rd_addr = 8'(a);
    #1;
    n_cmp++;
    if (rd_data !== 32'(exp)) begin
      n_bad++;
      $display("FAIL %s addr 0x%0h: actual %0d expected %0d", tag, a, rd_data, exp);
    end
    probe = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic set_time(input int y, input int mo, input int dm, input int dw,
                          input int h, input int mi, input int s);
    wr(CTRL, 1);
    wr(YR, y); wr(MO, mo); wr(DM, dm); wr(DW, dw); wr(HR, h); wr(MN, mi); wr(SC, s);
    wr(CTRL, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(CTRL, 1, "R1"); chk(YR, 0, "R1"); chk(MO, 1, "R1"); chk(DM, 1, "R1");
    chk(DW, 0, "R1"); chk(HR, 0, "R1"); chk(MN, 0, "R1"); chk(SC, 0, "R1");
    // R2 stopped at reset: ticks ignored
    ticks(3); chk(SC, 0, "R2");
    wr(CTRL, 32'hFFFF_FFF0); chk(CTRL, 0, "R2");
    ticks(5); chk(SC, 5, "R3");
    wr(CTRL, 1); ticks(4); chk(SC, 5, "R2"); chk(CTRL, 1, "R2");
    // R8 writes while stopped take effect
    wr(MN, 17); chk(MN, 17, "R8");
    wr(HR, 32'hFF); chk(HR, 31, "R8");
    wr(CTRL, 0);
    // R3 carry into hour
    set_time(10, 6, 10, 2, 7, 59, 58); ticks(2);
    chk(SC, 0, "R3"); chk(MN, 0, "R3"); chk(HR, 8, "R3");
    // R4/R6 non-leap Feb (year 3)
    set_time(3, 2, 28, 6, 23, 59, 59); ticks(1);
    chk(DM, 1, "R6"); chk(MO, 3, "R4"); chk(DW, 0, "R4");
    // R6 leap year 4
    set_time(4, 2, 28, 1, 23, 59, 59); ticks(1);
    chk(DM, 29, "R6"); chk(MO, 2, "R6");
    wr(HR, 23); wr(MN, 59); wr(SC, 59); ticks(1);
    chk(DM, 1, "R6"); chk(MO, 3, "R6");
    // R6 year 0 not leap
    set_time(0, 2, 28, 3, 23, 59, 59); ticks(1);
    chk(DM, 1, "R6"); chk(MO, 3, "R6");
    // R4 30-day month
    set_time(20, 4, 30, 5, 23, 59, 59); ticks(1);
    chk(DM, 1, "R4"); chk(MO, 5, "R4");
    // R5 year wrap
    set_time(99, 12, 31, 4, 23, 59, 59); ticks(1);
    chk(YR, 0, "R5"); chk(MO, 1, "R5"); chk(DM, 1, "R5"); chk(DW, 5, "R4");
    // R9 write and tick in the same cycle
    set_time(20, 5, 5, 1, 3, 4, 10);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(SC); wr_data = 32'd40; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    chk(SC, 40, "R9");
    // R10 seconds change with every carry
    wr(MN, 59); wr(SC, 59);
    chk(SC, 59, "R10");
    ticks(1);
    chk(SC, 0, "R10"); chk(MN, 0, "R10"); chk(HR, 4, "R10");
    // R11 unmapped addresses
    chk('h3C, 0, "R11"); chk('h5C, 0, "R11"); chk('h00, 0, "R11"); chk('hFF, 0, "R11");
    // R7 long run compared against model across the bank
    set_time(7, 12, 30, 0, 22, 30, 0);
    ticks(6000);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule